// File: doc/BRIEF.md
# Burst Address Counter for a Synchronous Memory Port

This block produces the address that one port of a synchronous memory uses in the current clock cycle. Each cycle it picks one of four operations from three active-low controls sampled on the port clock: clear the address to zero, take the address presented on the port's address pins, keep the address of the previous access, or advance it by one. The chosen address is driven out combinationally, so the memory sees it in the same cycle. The block also keeps it in a register, so the next cycle can hold it or step from it.

A burst is started by pulsing the load strobe with a start address. Later cycles assert the step enable and let the counter walk through consecutive locations while the address pins are free for other use. Because a clear takes effect in its own cycle, a burst that restarts at location zero loses no cycle. The data path, and whether its output is registered or not, is separate from the address. The same counter therefore serves bursts on either output timing. The address width is a parameter limited to 12 or 13 bits.

Top module: `burst_addr_counter`

## Requirements
- R1: While the active-high synchronous reset `rst` is high at a rising edge, the stored address becomes 0. The first hold cycle after reset therefore drives `cur_addr` = 0 whatever `ext_addr` carries.
- R2: When `clr_n` is 0, `cur_addr` is 0 in that same cycle, whatever the levels of `load_n`, `step_n` and `ext_addr`.
- R3: When `clr_n` is 1 and `load_n` is 0, `cur_addr` equals `ext_addr` in that same cycle, whatever the level of `step_n`.
- R4: When `clr_n`, `load_n` and `step_n` are all 1, `cur_addr` equals the address of the previous cycle, and `ext_addr` has no effect.
- R5: When `clr_n` and `load_n` are 1 and `step_n` is 0, `cur_addr` equals the previous cycle's address plus one.
- R6: A step from the all-ones address (4095 at the default width of 12) gives address 0.
- R7: A clear inserts no dead cycle. The cycle that follows a clear may step, and then gives address 1.
- R8: `ADDR_W` must be 12 or 13, and any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| rst | input | 1 | Active-high synchronous reset of the stored address |
| ext_addr | input | ADDR_W | Address presented on the port pins |
| load_n | input | 1 | Active-low strobe that takes `ext_addr` |
| step_n | input | 1 | Active-low enable that advances the address by one |
| clr_n | input | 1 | Active-low clear to address 0; highest priority |
| cur_addr | output | ADDR_W | Address used for the memory access in this cycle |

## Verification
Every result of this block is due in the same cycle as its controls, because `cur_addr` is a combinational choice over the stored address. Only the stored address, and so the base of the next hold or step, moves one edge later. The bench's driver applies controls on the falling edge and queues the address the requirements predict. The monitor compares a quarter period later, before the next rising edge, so each prediction meets the value of its own cycle. The prediction for the next cycle starts from the address predicted for the previous cycle, which checks the one-edge delay of the register as well.

// File: rtl/addr_ctr_pkg.sv
package addr_ctr_pkg;

   // Operation chosen each cycle, listed from highest to lowest priority.
   typedef enum logic [1:0] {
      CTR_CLEAR = 2'd0,
      CTR_LOAD  = 2'd1,
      CTR_HOLD  = 2'd2,
      CTR_STEP  = 2'd3
   } ctr_op_e;

   localparam int unsigned ADDR_W_NARROW = 12;
   localparam int unsigned ADDR_W_WIDE   = 13;

   function automatic bit width_supported(int unsigned w);
      return (w == ADDR_W_NARROW) || (w == ADDR_W_WIDE);
   endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
   import addr_ctr_pkg::*;
(
   input  logic    load_n,
   input  logic    step_n,
   input  logic    clr_n,
   output ctr_op_e op
);

   always_comb begin
      if (!clr_n)       op = CTR_CLEAR;
      else if (!load_n) op = CTR_LOAD;
      else if (!step_n) op = CTR_STEP;
      else              op = CTR_HOLD;
   end

endmodule

// File: rtl/burst_incrementer.sv
module burst_incrementer #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] a,
   output logic [ADDR_W-1:0] a_plus1
);

   localparam int unsigned CHAIN_LEN = ADDR_W + 1;

   logic [CHAIN_LEN-1:0] carry;

   assign carry[0] = 1'b1;

   // Half-adder chain; the carry out of the top bit is dropped, so the
   // all-ones address rolls over to zero.
   for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
      assign a_plus1[i]  = a[i] ^ carry[i];
      assign carry[i+1]  = a[i] & carry[i];
   end

   logic unused_carry;
   assign unused_carry = carry[CHAIN_LEN-1];

endmodule

// File: rtl/burst_addr_select.sv
module burst_addr_select
   import addr_ctr_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  ctr_op_e           op,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic [ADDR_W-1:0] held_addr,
   input  logic [ADDR_W-1:0] next_addr,
   output logic [ADDR_W-1:0] sel_addr
);

   always_comb begin
      unique case (op)
         CTR_CLEAR: sel_addr = '0;
         CTR_LOAD:  sel_addr = ext_addr;
         CTR_STEP:  sel_addr = next_addr;
         default:   sel_addr = held_addr;
      endcase
   end

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
   import addr_ctr_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] ext_addr,
   input  logic              load_n,
   input  logic              step_n,
   input  logic              clr_n,
   output logic [ADDR_W-1:0] cur_addr
);

   // R8: only the two supported widths elaborate.
   if (!width_supported(ADDR_W)) begin : g_bad_width
      $error("burst_addr_counter: ADDR_W must be 12 or 13");
   end

   ctr_op_e           op;
   logic [ADDR_W-1:0] held_q;
   logic [ADDR_W-1:0] stepped;

   burst_op_decode u_decode (
      .load_n (load_n),
      .step_n (step_n),
      .clr_n  (clr_n),
      .op     (op)
   );

   burst_incrementer #(.ADDR_W(ADDR_W)) u_inc (
      .a       (held_q),
      .a_plus1 (stepped)
   );

   burst_addr_select #(.ADDR_W(ADDR_W)) u_sel (
      .op        (op),
      .ext_addr  (ext_addr),
      .held_addr (held_q),
      .next_addr (stepped),
      .sel_addr  (cur_addr)
   );

   // The register keeps the address of this cycle's access.
   burst_addr_reg #(.ADDR_W(ADDR_W)) u_reg (
      .clk (clk),
      .rst (rst),
      .d   (cur_addr),
      .q   (held_q)
   );

endmodule

// File: rtl/burst_addr_counter_chk.sv
module burst_addr_counter_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] ext_addr,
   input logic              load_n,
   input logic              step_n,
   input logic              clr_n,
   input logic [ADDR_W-1:0] cur_addr
);

   logic [ADDR_W-1:0] prev_q;
   logic              after_rst_q;
   logic              prev_clr_q;

   always_ff @(posedge clk) begin
      prev_q      <= rst ? '0 : cur_addr;
      after_rst_q <= rst;
      prev_clr_q  <= rst ? 1'b0 : !clr_n;
   end

   assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
      !clr_n |-> cur_addr == '0);

   assert_load_ext_R3: assert property (@(posedge clk) disable iff (rst)
      (clr_n && !load_n) |-> cur_addr == ext_addr);

   assert_hold_prev_R4: assert property (@(posedge clk) disable iff (rst)
      (clr_n && load_n && step_n) |-> cur_addr == prev_q);

   assert_step_prev_R5: assert property (@(posedge clk) disable iff (rst)
      (clr_n && load_n && !step_n) |-> cur_addr == ADDR_W'(prev_q + 1'b1));

   assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (clr_n && load_n && !step_n && &prev_q) |-> cur_addr == '0);

   assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
      (after_rst_q && clr_n && load_n && step_n) |-> cur_addr == '0);

   assert_no_dead_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      (prev_clr_q && clr_n && load_n && !step_n) |-> cur_addr == ADDR_W'(1));

endmodule

bind burst_addr_counter burst_addr_counter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .ext_addr (ext_addr),
   .load_n   (load_n),
   .step_n   (step_n),
   .clr_n    (clr_n),
   .cur_addr (cur_addr)
);

// File: tb/test_burst_addr_counter.sv
module test_burst_addr_counter;

   localparam int unsigned ADDR_W     = 12;
   localparam time         CLK_PERIOD = 10ns;
   localparam int unsigned WATCHDOG   = 200000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] ext_addr = '0;
   logic              load_n = 1'b1;
   logic              step_n = 1'b1;
   logic              clr_n  = 1'b1;
   logic [ADDR_W-1:0] cur_addr;

   int unsigned n_cmp  = 0;
   int unsigned n_fail = 0;
   bit          done   = 1'b0;

   logic [ADDR_W-1:0] exp_q[$];
   string             tag_q[$];
   logic [ADDR_W-1:0] model_prev = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_addr_counter #(.ADDR_W(ADDR_W)) i_burst_addr_counter (
      .clk      (clk),
      .rst      (rst),
      .ext_addr (ext_addr),
      .load_n   (load_n),
      .step_n   (step_n),
      .clr_n    (clr_n),
      .cur_addr (cur_addr)
   );

   // Driver: one cycle of controls plus the predicted address for it.
   task automatic cycle(input bit c_n, input bit l_n, input bit s_n,
                        input logic [ADDR_W-1:0] ext, input string req);
      logic [ADDR_W-1:0] e;
      @(negedge clk);
      rst = 1'b0; clr_n = c_n; load_n = l_n; step_n = s_n; ext_addr = ext;
      if (!c_n)      e = '0;
      else if (!l_n) e = ext;
      else if (!s_n) e = ADDR_W'(model_prev + 1'b1);
      else           e = model_prev;
      model_prev = e;
      exp_q.push_back(e);
      tag_q.push_back(req);
   endtask

   task automatic sys_reset(input int unsigned n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rst = 1'b1; clr_n = 1'b1; load_n = 1'b1; step_n = 1'b1;
         ext_addr = ADDR_W'(12'h9A5);
      end
      model_prev = '0;
   endtask

   // Monitor: compares before the next rising edge.
   always @(negedge clk) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
         logic [ADDR_W-1:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_cmp++;
         if (cur_addr !== e) begin
            n_fail++;
            $display("FAIL %s: cur_addr=%0h expected=%0h", t, cur_addr, e);
         end
      end
   end

   initial begin
      #(CLK_PERIOD*WATCHDOG);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
         $finish;
      end
   end

   initial begin
      sys_reset(3);
      // R1: first hold after reset is 0 regardless of ext_addr
      cycle(1, 1, 1, 12'hABC, "R1");
      // R5: consecutive steps
      cycle(1, 1, 0, 12'h111, "R5");
      cycle(1, 1, 0, 12'h222, "R5");
      cycle(1, 1, 0, 12'h333, "R5");
      // R3: load overrides the step enable
      cycle(1, 0, 0, 12'h123, "R3");
      cycle(1, 1, 0, 12'h000, "R5");
      // R4: holds ignore ext_addr
      cycle(1, 1, 1, 12'h555, "R4");
      cycle(1, 1, 1, 12'hAAA, "R4");
      // R2: clear overrides load and step
      cycle(0, 0, 0, 12'h777, "R2");
      // R7: step directly after clear gives 1
      cycle(1, 1, 0, 12'h777, "R7");
      cycle(1, 1, 0, 12'h777, "R7");
      // R6: wrap at the top
      cycle(1, 0, 1, 12'hFFE, "R3");
      cycle(1, 1, 0, 12'h000, "R6");
      cycle(1, 1, 0, 12'h000, "R6");
      cycle(1, 1, 0, 12'h000, "R5");
      cycle(1, 0, 1, 12'hFFF, "R3");
      cycle(1, 1, 1, 12'h000, "R4");
      cycle(1, 1, 0, 12'h000, "R6");
      // R2: clear with load high and step high
      cycle(1, 0, 1, 12'h456, "R3");
      cycle(0, 1, 1, 12'h456, "R2");
      cycle(1, 1, 1, 12'h456, "R4");
      // R1: mid-run system reset
      cycle(1, 0, 1, 12'h200, "R3");
      sys_reset(1);
      cycle(1, 1, 1, 12'h3C3, "R1");
      cycle(1, 1, 0, 12'h3C3, "R5");
      // mixed stimulus
      for (int i = 0; i < 400; i++) begin
         int unsigned r;
         r = $urandom;
         cycle((r % 11) != 0, (r[7:4] % 5) != 0, r[8],
               ADDR_W'(r >> 12), "R4/R5 mixed");
      end
      @(negedge clk);
      @(negedge clk);
      #(CLK_PERIOD/2);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
   end

endmodule